// File: doc/BRIEF.md
# Command Port Register Routing Controller

This block sits behind the command port of a content-addressable memory and decides where each port access lands. Command-port writes are normally decoded as instructions, and command-port reads normally return the status word. Two selection instructions set the standing source for data-port reads and the standing target for data-port writes. A one-shot override instruction redirects only the next command-port access to a named register, after which the port falls back to its normal routing.

A selection instruction may carry an address flag. When the flag is set, the next command-port write is taken as an absolute address for the address register and is not decoded. When the standing source or target is memory at the address register, each qualifying data access moves that register by one. A control bit sets the direction of the step. The match array, the compare logic and the data registers themselves live outside this block.

Top module: `cpr_route_ctl`

## Requirements
- R1: While reset is low, and after it is released, source and target selections are 000 (comparand), the address-cycle flag is 0, the address is 0, the control word is 0, read data is 0, and no override is pending.
- R2: A source-select word has the form 0000_f000_0000_0ccc and a target-select word the form 0000_f001_xxcc_cxxx. Valid selection codes are 000 comparand, 001 mask one, 010 mask two and 100 memory at the address register. A valid word updates the matching selection output one clock after the write strobe.
- R3: A selection word carrying code 011, 101, 110 or 111, and any word matching no instruction form, leaves every output and all pending state unchanged.
- R4: A valid selection word with f=1 raises the address-cycle flag. The next command write loads its low AW bits into the address, clears the flag, and is not decoded as an instruction.
- R5: A command read with no override pending captures the status input into the read data one clock later.
- R6: An override word 0000_0010_00cc_c000 with code 000 control, 001 source-view, 010 target-view, 011 next-free or 100 address arms a one-shot override; codes 101 to 111 leave it unarmed. The next command read returns, respectively: the control word; the device ID in bits 15..4 with the source code in bits 2..0; the target code in bits 2..0; the next-free input; or the zero-extended address. Later reads return status again.
- R7: A command write under override stores into the control word (code 000) or the address (code 100). For codes 001, 010 and 011 it is discarded. In every case it is not decoded, and it clears the override.
- R8: A data read while the source is 100, and a data write while the target is 100, each step the address by one: upward when control bit 0 is 0, downward when it is 1. Both in one cycle step by two. Accesses with other selections leave the address unchanged.
- R9: When command write and command read strobe in the same cycle, only the write is acted on, and the read data holds its value.
- R10: Address stepping wraps modulo 2^AW in both directions, and an address load in the same cycle as a step takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command-port write strobe |
| cmd_wdata_i | input | 16 | Command-port write data |
| cmd_rd_i | input | 1 | Command-port read strobe |
| dat_rd_i | input | 1 | Data-port read strobe |
| dat_wr_i | input | 1 | Data-port write strobe |
| status_i | input | 16 | Status word returned on plain command reads |
| nf_i | input | 16 | Next-free address word from the match logic |
| src_sel_o | output | 3 | Current data-read source code |
| dst_sel_o | output | 3 | Current data-write target code |
| addr_pend_o | output | 1 | Next command write is an address cycle |
| addr_o | output | AW | Address register |
| cmd_rdata_o | output | 16 | Command-port read data |

## Verification
Every result is registered, so each strobe presented in one cycle shows its effect on the outputs exactly one clock later. This covers a selection change, a raised or cleared address flag, an address load or step, and captured read data. The bench drives inputs just after a rising edge and advances a behavioural model on that same edge. It compares every output at the following falling edge, which is where the one-cycle latency puts the due value. Multi-step sequences, such as an override followed by its access, or an address-flagged select followed by its address word, are therefore checked cycle by cycle rather than only at the end.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam logic [2:0] SEL_CMP  = 3'b000;
  localparam logic [2:0] SEL_MSK1 = 3'b001;
  localparam logic [2:0] SEL_MSK2 = 3'b010;
  localparam logic [2:0] SEL_MEM  = 3'b100;

  localparam logic [2:0] OV_CTL = 3'd0;
  localparam logic [2:0] OV_SRC = 3'd1;
  localparam logic [2:0] OV_DST = 3'd2;
  localparam logic [2:0] OV_NF  = 3'd3;
  localparam logic [2:0] OV_AR  = 3'd4;

  typedef enum logic [1:0] {OP_NONE, OP_SRC, OP_DST, OP_OVR} op_e;

  typedef struct packed {
    op_e        op;
    logic       afl;
    logic [2:0] code;
  } dec_t;

  function automatic logic sel_code_ok(input logic [2:0] c);
    return (c == SEL_CMP) || (c == SEL_MSK1) || (c == SEL_MSK2) || (c == SEL_MEM);
  endfunction
endpackage

// File: rtl/cpr_decode.sv
module cpr_decode
  import cpr_pkg::*;
(
  input  logic [15:0] word_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o = '{op: OP_NONE, afl: 1'b0, code: 3'b000};
    if (word_i[15:12] == 4'h0) begin
      unique case (word_i[10:8])
        3'b000: if (word_i[7:3] == 5'b0 && sel_code_ok(word_i[2:0]))
                  dec_o = '{op: OP_SRC, afl: word_i[11], code: word_i[2:0]};
        3'b001: if (sel_code_ok(word_i[5:3]))
                  dec_o = '{op: OP_DST, afl: word_i[11], code: word_i[5:3]};
        3'b010: if (!word_i[11] && word_i[7:6] == 2'b00 && word_i[2:0] == 3'b000
                    && word_i[5:3] <= OV_AR)
                  dec_o = '{op: OP_OVR, afl: 1'b0, code: word_i[5:3]};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpr_addr.sv
module cpr_addr #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_rd_i,
  input  logic          step_wr_i,
  input  logic          dir_dn_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, nstep;

  assign nstep  = AW'(step_rd_i) + AW'(step_wr_i);
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (load_i)    addr_q <= load_val_i;
    else if (dir_dn_i)  addr_q <= addr_q - nstep;
    else                addr_q <= addr_q + nstep;
  end

  assert_addr_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_rd_i && !step_wr_i) |=> $stable(addr_q));
  assert_addr_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (step_rd_i || step_wr_i)) |=> (addr_q == $past(load_val_i)));
endmodule

// File: rtl/cpr_rdmux.sv
module cpr_rdmux
  import cpr_pkg::*;
#(
  parameter int          AW     = 10,
  parameter logic [11:0] DEV_ID = 12'h5C1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          ovr_i,
  input  logic [2:0]    ovr_code_i,
  input  logic [15:0]   status_i,
  input  logic [15:0]   ctl_i,
  input  logic [2:0]    src_i,
  input  logic [2:0]    dst_i,
  input  logic [15:0]   nf_i,
  input  logic [AW-1:0] addr_i,
  output logic [15:0]   rdata_o
);
  logic [15:0] sel_d, rdata_q;

  always_comb begin
    sel_d = status_i;
    if (ovr_i) begin
      unique case (ovr_code_i)
        OV_CTL:  sel_d = ctl_i;
        OV_SRC:  sel_d = {DEV_ID, 1'b0, src_i};
        OV_DST:  sel_d = {13'b0, dst_i};
        OV_NF:   sel_d = nf_i;
        default: sel_d = 16'(addr_i);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= sel_d;
  end

  assign rdata_o = rdata_q;

  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_q));
endmodule

// File: rtl/cpr_route_ctl.sv
module cpr_route_ctl
  import cpr_pkg::*;
#(
  parameter int          AW     = 10,
  parameter logic [11:0] DEV_ID = 12'h5C1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic [15:0]   cmd_wdata_i,
  input  logic          cmd_rd_i,
  input  logic          dat_rd_i,
  input  logic          dat_wr_i,
  input  logic [15:0]   status_i,
  input  logic [15:0]   nf_i,
  output logic [2:0]    src_sel_o,
  output logic [2:0]    dst_sel_o,
  output logic          addr_pend_o,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   cmd_rdata_o
);
  dec_t        dec;
  logic [2:0]  src_q, dst_q, ovr_code_q;
  logic        ovr_q, pend_q;
  logic [15:0] ctl_q;
  logic        decode_en, ovr_wr, ar_load, rd_en;

  cpr_decode u_dec (.word_i(cmd_wdata_i), .dec_o(dec));

  assign decode_en = cmd_wr_i && !pend_q && !ovr_q;
  assign ovr_wr    = cmd_wr_i && !pend_q && ovr_q;
  assign ar_load   = (cmd_wr_i && pend_q) || (ovr_wr && ovr_code_q == OV_AR);
  assign rd_en     = cmd_rd_i && !cmd_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q      <= SEL_CMP;
      dst_q      <= SEL_CMP;
      ovr_q      <= 1'b0;
      ovr_code_q <= OV_CTL;
      pend_q     <= 1'b0;
      ctl_q      <= '0;
    end else if (cmd_wr_i) begin
      if (pend_q) begin
        pend_q <= 1'b0;
      end else if (ovr_q) begin
        ovr_q <= 1'b0;
        if (ovr_code_q == OV_CTL) ctl_q <= cmd_wdata_i;
      end else begin
        unique case (dec.op)
          OP_SRC: begin src_q <= dec.code; pend_q <= dec.afl; end
          OP_DST: begin dst_q <= dec.code; pend_q <= dec.afl; end
          OP_OVR: begin ovr_q <= 1'b1; ovr_code_q <= dec.code; end
          default: ;
        endcase
      end
    end else if (cmd_rd_i) begin
      ovr_q <= 1'b0;
    end
  end

  cpr_addr #(.AW(AW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ar_load),
    .load_val_i (cmd_wdata_i[AW-1:0]),
    .step_rd_i  (dat_rd_i && src_q == SEL_MEM),
    .step_wr_i  (dat_wr_i && dst_q == SEL_MEM),
    .dir_dn_i   (ctl_q[0]),
    .addr_o     (addr_o)
  );

  cpr_rdmux #(.AW(AW), .DEV_ID(DEV_ID)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en),
    .ovr_i      (ovr_q),
    .ovr_code_i (ovr_code_q),
    .status_i   (status_i),
    .ctl_i      (ctl_q),
    .src_i      (src_q),
    .dst_i      (dst_q),
    .nf_i       (nf_i),
    .addr_i     (addr_o),
    .rdata_o    (cmd_rdata_o)
  );

  assign src_sel_o   = src_q;
  assign dst_sel_o   = dst_q;
  assign addr_pend_o = pend_q;

  assert_sel_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_code_ok(src_q) && sel_code_ok(dst_q));
  assert_sel_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr_i |=> ($stable(src_sel_o) && $stable(dst_sel_o)));
  assert_pend_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cmd_wr_i) |=> (!pend_q && $stable(src_sel_o) && $stable(dst_sel_o)));
  assert_status_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd_i && !cmd_wr_i && !ovr_q) |=> (cmd_rdata_o == $past(status_i)));
  assert_ovr_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && (cmd_rd_i || cmd_wr_i)) |=> !ovr_q);
  assert_ovr_nodecode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && cmd_wr_i) |=> ($stable(src_sel_o) && $stable(dst_sel_o) && !pend_q));
  assert_ovr_pend_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovr_q && pend_q));
endmodule

// File: tb/sim_cpr_route_ctl.sv
module sim_cpr_route_ctl;
  localparam int AW = 10;
  localparam int AMOD = 1 << AW;
  localparam logic [11:0] ID = 12'h5C1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, cmd_rd = 0, dat_rd = 0, dat_wr = 0;
  logic [15:0] cmd_wdata = '0, status = 16'hA5C3, nf = 16'h0123;
  logic [2:0]  src_sel, dst_sel;
  logic        addr_pend;
  logic [AW-1:0] addr;
  logic [15:0] cmd_rdata;

  always #10 clk = ~clk;

  cpr_route_ctl #(.AW(AW), .DEV_ID(ID)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
    .cmd_rd_i(cmd_rd), .dat_rd_i(dat_rd), .dat_wr_i(dat_wr), .status_i(status),
    .nf_i(nf), .src_sel_o(src_sel), .dst_sel_o(dst_sel), .addr_pend_o(addr_pend),
    .addr_o(addr), .cmd_rdata_o(cmd_rdata));

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";
  bit started = 0;

  // behavioural reference
  int m_src, m_dst, m_pend, m_addr, m_ovr, m_ovc, m_ctl, m_rd;

  function automatic bit code_ok(int c);
    return c == 0 || c == 1 || c == 2 || c == 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int n, o_src, o_dst, o_addr, w;
    bit loaded;
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_pend = 0; m_addr = 0;
      m_ovr = 0; m_ovc = 0; m_ctl = 0; m_rd = 0;
    end else begin
      started = 1;
      o_src = m_src; o_dst = m_dst; o_addr = m_addr; w = cmd_wdata;
      loaded = 0;
      n = ((dat_rd && o_src == 4) ? 1 : 0) + ((dat_wr && o_dst == 4) ? 1 : 0);
      if (cmd_wr) begin
        if (m_pend != 0) begin
          m_addr = w % AMOD; m_pend = 0; loaded = 1;
        end else if (m_ovr != 0) begin
          m_ovr = 0;
          if (m_ovc == 0) m_ctl = w;
          else if (m_ovc == 4) begin m_addr = w % AMOD; loaded = 1; end
        end else if ((w & 16'hF7F8) == 0 && code_ok(w & 7)) begin
          m_src = w & 7; m_pend = (w >> 11) & 1;
        end else if ((w & 16'hF700) == 16'h0100 && code_ok((w >> 3) & 7)) begin
          m_dst = (w >> 3) & 7; m_pend = (w >> 11) & 1;
        end else if ((w & 16'hFFC7) == 16'h0200 && ((w >> 3) & 7) <= 4) begin
          m_ovr = 1; m_ovc = (w >> 3) & 7;
        end
      end else if (cmd_rd) begin
        if (m_ovr == 0) m_rd = status;
        else case (m_ovc)
          0: m_rd = m_ctl;
          1: m_rd = (ID << 4) | o_src;
          2: m_rd = o_dst;
          3: m_rd = nf;
          default: m_rd = o_addr;
        endcase
        m_ovr = 0;
      end
      if (!loaded)
        m_addr = (o_addr + 4 * AMOD + (((m_ctl_dir(o_addr)) != 0) ? -n : n)) % AMOD;
    end
  end

  // direction is read before any control write of the same cycle
  int ctl_prev = 0;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_prev <= 0; else ctl_prev <= m_ctl;
  function automatic int m_ctl_dir(int unused);
    return ctl_prev & 1;
  endfunction

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    cmp("src_sel", src_sel, m_src);
    cmp("dst_sel", dst_sel, m_dst);
    cmp("addr_pend", addr_pend, m_pend);
    cmp("addr", addr, m_addr);
    cmp("cmd_rdata", cmd_rdata, m_rd);
  end

  task automatic cyc(bit w, logic [15:0] d, bit r, bit drd, bit dwr);
    @(posedge clk); #1;
    cmd_wr = w; cmd_wdata = d; cmd_rd = r; dat_rd = drd; dat_wr = dwr;
    @(posedge clk); #1;
    cmd_wr = 0; cmd_rd = 0; dat_rd = 0; dat_wr = 0;
  endtask
  task automatic wr(logic [15:0] d); cyc(1, d, 0, 0, 0); endtask
  task automatic rd(); cyc(0, '0, 1, 0, 0); endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      finish_up();
    end
  end

  initial begin
    phase = "R1"; repeat (3) @(posedge clk);
    #1 rst_n = 1;
    phase = "R5"; rd();
    status = 16'h3C5A; rd();
    phase = "R2"; wr(16'h0001); wr(16'h0110); wr(16'h0002); wr(16'h0100);
    phase = "R3"; wr(16'h0003); wr(16'h0138); wr(16'h1234); wr(16'h0028); wr(16'h0207);
    phase = "R6"; wr(16'h0208); rd(); rd();
    wr(16'h0210); rd(); wr(16'h0218); rd(); wr(16'h0220); rd();
    phase = "R4"; wr(16'h0804); wr(16'h03FE);
    phase = "R10"; cyc(0, '0, 0, 1, 0); cyc(0, '0, 0, 1, 0); cyc(0, '0, 0, 1, 0);
    phase = "R7"; wr(16'h0200); wr(16'h0001); wr(16'h0200); rd();
    phase = "R8"; cyc(0, '0, 0, 1, 0); cyc(0, '0, 0, 1, 0); cyc(0, '0, 0, 1, 1);
    phase = "R4"; wr(16'h0920); wr(16'h0005);
    phase = "R8"; cyc(0, '0, 0, 0, 1); cyc(0, '0, 0, 1, 1); cyc(0, '0, 0, 1, 1);
    phase = "R7"; wr(16'h0208); wr(16'h0001); wr(16'h0210); wr(16'h0000);
    wr(16'h0218); wr(16'h0004); wr(16'h0220); wr(16'h0155);
    phase = "R10"; wr(16'h0804); cyc(1, 16'h0000, 0, 1, 1);
    phase = "R9"; wr(16'h0208); cyc(1, 16'h0000, 1, 0, 0); rd();
    phase = "R8"; wr(16'h0001); wr(16'h0108); cyc(0, '0, 0, 1, 1);
    phase = "R1"; wr(16'h0208); wr(16'h0804);
    @(posedge clk); #1 rst_n = 0; @(posedge clk); #1 rst_n = 1;
    rd();
    repeat (2) @(posedge clk);
    finish_up();
  end
endmodule